// File: doc/BRIEF.md
# Hold and Ready/Busy Pin Controller

This block owns one multi-purpose pin of a serial memory's SPI slave port. A two-bit mode input chooses what the pin does. It can be a hold input that pauses the SPI command in flight without losing it. It can be ignored entirely. It can also report whether the memory array is ready or busy, either with a full push-pull drive or with a low-only open-drain drive that relies on an external pull-up.

The SPI lines and the pin input are asynchronous to the block clock, so they pass through a synchroniser first. Hold is a registered state. It is entered when the pin falls while chip select (active low) and SCK are both low. It is left when the pin rises under the same bus condition, or when the chip is deselected, or when the mode leaves hold-input.

The block qualifies the command shifter. It emits a one-cycle shift strobe with the sampled SI bit for each SCK rising edge that is accepted. It also produces the SO output enable, which is off while the chip is deselected or on hold. Mode, busy and the shifter are owned elsewhere. This interface carries no streamed payload, so all pins are plain level or pulse signals with no back-pressure.

Top module: `hrb_pin_ctrl`

## Requirements
- R1: With mode 2'b01 (unused pin), pin_oe is 0, hold_active stays 0 whatever pin_in does, and SCK rising edges keep producing shift strobes.
- R2: With mode 2'b11 (push-pull ready/busy), pin_oe is 1 and pin_o is 1 when busy is 0 and 0 when busy is 1.
- R3: With mode 2'b10 (open-drain ready/busy), pin_oe is 1 with pin_o 0 while busy is 1, and pin_oe is 0 while busy is 0.
- R4: With mode 2'b00 (hold input), pin_oe is 0.
- R5: In mode 2'b00, a falling pin_in while cs_n and sck are both low sets hold_active.
- R6: A falling pin_in while sck is high, or while cs_n is high, leaves hold_active at 0. This includes a fall sampled in the same cycle as an SCK rise, in which case the SCK edge still shifts.
- R7: While hold_active is 1, so_oe is 0 and SCK rising edges produce no shift strobe.
- R8: hold_active clears only on a rising pin_in while cs_n and sck are low. A rise while sck is high, or a further fall, keeps the hold. After release, shifting continues, so the bits before and after the hold form one unbroken word.
- R9: cs_n going high clears hold_active and forces so_oe to 0. When cs_n returns low with pin_in already low, the block is not on hold and so_oe is 1.
- R10: Changing the mode away from 2'b00 clears hold_active.
- R11: Each accepted SCK rising edge (cs_n low, not on hold) gives exactly one shift_stb pulse, with shift_bit equal to SI at that edge.
- R12: While rst_n is low, hold_active, so_oe and shift_stb are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Pin function: 00 hold, 01 unused, 10 open-drain R/B, 11 push-pull R/B |
| busy | input | 1 | Array busy flag, synchronous to clk |
| cs_n | input | 1 | SPI chip select, active low, asynchronous |
| sck | input | 1 | SPI serial clock, asynchronous |
| si | input | 1 | SPI serial data in, asynchronous |
| pin_in | input | 1 | Pad input of the multi-purpose pin |
| pin_oe | output | 1 | Pad output enable of the multi-purpose pin |
| pin_o | output | 1 | Pad output value of the multi-purpose pin |
| so_oe | output | 1 | SO pad output enable |
| hold_active | output | 1 | Command is suspended |
| shift_stb | output | 1 | One-cycle pulse per accepted SCK rising edge |
| shift_bit | output | 1 | SI value captured with shift_stb |

## Verification
A hold-pin fall and an SCK rising edge can land in the same sampled cycle. The hold decision and the shift decision then meet in one clock. The bench provokes this by changing pin_in and sck in a single drive step. It then judges that hold_active stays 0 and that the strobe count rises by exactly one. A second pairing is a chip-select rise during a hold: the abort must win, and a later reselect must not resurrect the hold.

// File: rtl/hrb_pkg.sv
package hrb_pkg;
  typedef enum logic [1:0] {
    PM_HOLD  = 2'b00,
    PM_NONE  = 2'b01,
    PM_RB_OD = 2'b10,
    PM_RB_PP = 2'b11
  } pin_mode_e;

  localparam int unsigned BUS_W   = 4;
  localparam int unsigned IX_PIN  = 0;
  localparam int unsigned IX_SI   = 1;
  localparam int unsigned IX_SCK  = 2;
  localparam int unsigned IX_CSN  = 3;
  // reset levels: deselected, clock low, data low, pin high
  localparam logic [BUS_W-1:0] BUS_IDLE = 4'b1001;
endpackage

// File: rtl/hrb_sync.sv
module hrb_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 4,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int unsigned NST = (STAGES < 1) ? 1 : STAGES;
  logic [W-1:0] stg [NST];

  for (genvar i = 0; i < NST; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_V;
        else        stg[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_V;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[NST-1];
endmodule

// File: rtl/hrb_hold_fsm.sv
module hrb_hold_fsm
  import hrb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pin_mode_e mode,
  input  logic      cs_n_s,
  input  logic      sck_s,
  input  logic      pin_s,
  output logic      hold_q
);
  logic pin_prev;
  logic fall_ok, rise_ok, bus_quiet;
  logic hold_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_prev <= 1'b1;
    else        pin_prev <= pin_s;

  assign bus_quiet = !cs_n_s && !sck_s;
  assign fall_ok   = bus_quiet && pin_prev && !pin_s;
  assign rise_ok   = bus_quiet && !pin_prev && pin_s;

  always_comb begin
    hold_d = hold_q;
    if (cs_n_s || mode != PM_HOLD) hold_d = 1'b0;
    else if (!hold_q && fall_ok)   hold_d = 1'b1;
    else if (hold_q && rise_ok)    hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
endmodule

// File: rtl/hrb_rb_drive.sv
module hrb_rb_drive
  import hrb_pkg::*;
(
  input  pin_mode_e mode,
  input  logic      busy,
  output logic      oe,
  output logic      o
);
  always_comb begin
    oe = 1'b0;
    o  = 1'b0;
    unique case (mode)
      PM_RB_PP: begin oe = 1'b1; o = !busy; end
      PM_RB_OD: begin oe = busy; o = 1'b0;  end
      default:  begin oe = 1'b0; o = 1'b0;  end
    endcase
  end
endmodule

// File: rtl/hrb_shift_gate.sv
module hrb_shift_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_s,
  input  logic sck_s,
  input  logic si_s,
  input  logic hold_q,
  output logic stb,
  output logic bit_o
);
  logic sck_prev;
  logic accept;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;

  assign accept = !sck_prev && sck_s && !cs_n_s && !hold_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stb   <= 1'b0;
      bit_o <= 1'b0;
    end else begin
      stb <= accept;
      if (accept) bit_o <= si_s;
    end
endmodule

// File: rtl/hrb_pin_ctrl.sv
module hrb_pin_ctrl
  import hrb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       busy,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  input  logic       pin_in,
  output logic       pin_oe,
  output logic       pin_o,
  output logic       so_oe,
  output logic       hold_active,
  output logic       shift_stb,
  output logic       shift_bit
);
  logic [BUS_W-1:0] bus_raw, bus_s;
  logic cs_n_s, sck_s, si_s, pin_s;
  pin_mode_e mode_e;

  assign mode_e = pin_mode_e'(mode);

  always_comb begin
    bus_raw         = '0;
    bus_raw[IX_CSN] = cs_n;
    bus_raw[IX_SCK] = sck;
    bus_raw[IX_SI]  = si;
    bus_raw[IX_PIN] = pin_in;
  end

  hrb_sync #(.STAGES(SYNC_STAGES), .W(BUS_W), .RST_V(BUS_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
  );

  assign cs_n_s = bus_s[IX_CSN];
  assign sck_s  = bus_s[IX_SCK];
  assign si_s   = bus_s[IX_SI];
  assign pin_s  = bus_s[IX_PIN];

  hrb_hold_fsm u_hold (
    .clk(clk), .rst_n(rst_n), .mode(mode_e),
    .cs_n_s(cs_n_s), .sck_s(sck_s), .pin_s(pin_s), .hold_q(hold_active)
  );

  hrb_rb_drive u_drv (
    .mode(mode_e), .busy(busy), .oe(pin_oe), .o(pin_o)
  );

  hrb_shift_gate u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_s(sck_s), .si_s(si_s),
    .hold_q(hold_active), .stb(shift_stb), .bit_o(shift_bit)
  );

  assign so_oe = !cs_n_s && !hold_active;
endmodule

// File: rtl/hrb_pin_ctrl_chk.sv
module hrb_pin_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       busy,
  input logic       cs_n_s,
  input logic       sck_s,
  input logic       pin_s,
  input logic       pin_oe,
  input logic       pin_o,
  input logic       so_oe,
  input logic       hold_active,
  input logic       shift_stb
);
  a_r1_unused_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> !pin_oe);

  a_r3_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && pin_oe) |-> (!pin_o && busy));

  a_r5_entry_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> $past(!cs_n_s && !sck_s && !pin_s && mode == 2'b00));

  a_r8_exit_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_active) |-> $past(cs_n_s || mode != 2'b00 || (!sck_s && pin_s)));

  a_r7_no_shift_on_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_active) |-> !shift_stb);

  a_r7_so_off_on_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !so_oe);

  a_r9_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n_s) |-> !hold_active);
endmodule

bind hrb_pin_ctrl hrb_pin_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .busy(busy),
  .cs_n_s(cs_n_s), .sck_s(sck_s), .pin_s(pin_s),
  .pin_oe(pin_oe), .pin_o(pin_o), .so_oe(so_oe),
  .hold_active(hold_active), .shift_stb(shift_stb)
);

// File: tb/tb_hrb_pin_ctrl.sv
module tb_hrb_pin_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic busy = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, pin_in = 1'b1;
  logic pin_oe, pin_o, so_oe, hold_active, shift_stb, shift_bit;

  int n_chk = 0, n_bad = 0;
  int stb_cnt = 0;
  logic [7:0] cap = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hrb_pin_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .busy(busy), .cs_n(cs_n),
    .sck(sck), .si(si), .pin_in(pin_in), .pin_oe(pin_oe), .pin_o(pin_o),
    .so_oe(so_oe), .hold_active(hold_active), .shift_stb(shift_stb),
    .shift_bit(shift_bit)
  );

  always @(posedge clk)
    if (shift_stb) begin
      stb_cnt <= stb_cnt + 1;
      cap     <= {cap[6:0], shift_bit};
    end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic pulse_sck(input logic b);
    si = b; settle();
    sck = 1'b1; settle();
    sck = 1'b0; settle();
  endtask

  task automatic send(input logic [7:0] w, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) pulse_sck(w[7-i]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk("R12 hold", hold_active, 0);
    chk("R12 so_oe", so_oe, 0);
    chk("R12 stb", shift_stb, 0);
    rst_n = 1'b1; settle();

    // driver sweep over every mode and busy value
    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 2; b++) begin
        string tg;
        int eoe;
        mode = m[1:0]; busy = b[0]; settle();
        tg  = (m == 0) ? "R4" : (m == 1) ? "R1" : (m == 2) ? "R3" : "R2";
        eoe = (m == 3) ? 1 : (m == 2) ? b : 0;
        chk({tg, " pin_oe"}, pin_oe, eoe);
        if (eoe == 1) chk({tg, " pin_o"}, pin_o, (m == 3) ? 1 - b : 0);
      end

    // plain word, hold mode, no hold
    mode = 2'b00; busy = 1'b0;
    cs_n = 1'b0; settle();
    chk("R9 so_oe selected", so_oe, 1);
    base = stb_cnt;
    send(8'hA5, 0, 7);
    chk("R11 count", stb_cnt - base, 8);
    chk("R11 word", cap, 8'hA5);

    // hold in the middle of a word
    base = stb_cnt;
    send(8'h3C, 0, 3);
    pin_in = 1'b0; settle();
    chk("R5 hold set", hold_active, 1);
    chk("R7 so_oe off", so_oe, 0);
    pulse_sck(1'b1); pulse_sck(1'b1); pulse_sck(1'b0);
    chk("R7 no strobes", stb_cnt - base, 4);
    sck = 1'b1; settle();
    pin_in = 1'b1; settle();
    sck = 1'b0; settle();
    chk("R8 rise with sck high", hold_active, 1);
    pin_in = 1'b0; settle();
    chk("R8 fall while held", hold_active, 1);
    pin_in = 1'b1; settle();
    chk("R8 release", hold_active, 0);
    chk("R8 so_oe back", so_oe, 1);
    send(8'h3C, 4, 7);
    chk("R8 count", stb_cnt - base, 8);
    chk("R8 word continues", cap, 8'h3C);

    // fall and SCK rise in the same step
    base = stb_cnt;
    si = 1'b1;
    pin_in = 1'b0; sck = 1'b1; settle();
    chk("R6 same-cycle no hold", hold_active, 0);
    chk("R6 same-cycle shifts", stb_cnt - base, 1);
    sck = 1'b0; settle();
    chk("R6 no late hold", hold_active, 0);
    pin_in = 1'b1; settle();

    // fall while deselected
    cs_n = 1'b1; settle();
    pin_in = 1'b0; settle();
    cs_n = 1'b0; settle();
    chk("R6 fall while deselected", hold_active, 0);
    pin_in = 1'b1; settle();

    // deselect aborts hold
    pin_in = 1'b0; settle();
    chk("R5 hold set again", hold_active, 1);
    cs_n = 1'b1; settle();
    chk("R9 abort hold", hold_active, 0);
    chk("R9 so_oe off", so_oe, 0);
    cs_n = 1'b0; settle();
    chk("R9 reselect no hold", hold_active, 0);
    chk("R9 reselect so_oe", so_oe, 1);
    pin_in = 1'b1; settle();

    // leaving hold mode clears the state
    pin_in = 1'b0; settle();
    chk("R5 hold set third", hold_active, 1);
    mode = 2'b01; settle();
    chk("R10 mode exit clears", hold_active, 0);
    pin_in = 1'b1; settle();
    pin_in = 1'b0; settle();
    chk("R1 pin ignored", hold_active, 0);
    chk("R1 no drive", pin_oe, 0);
    base = stb_cnt;
    pulse_sck(1'b0);
    chk("R1 still shifts", stb_cnt - base, 1);
    chk("R11 bit value", shift_bit, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule